// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Bank

This block is the byte-wide host side of a two-channel asynchronous serial controller. Each channel owns sixteen write registers and sixteen read registers. The host cannot address them directly. It first writes a register number into the channel's control port, and the next control access then reaches that register. A small per-channel pointer machine holds the register number. The machine has two states. `PTR_HOME` means the pointer is 0, so the next control write is taken as a pointer load or command. `PTR_AIMED` means the pointer holds a register number from 1 to 15. The transition HOME→AIMED happens on a control write that produces a nonzero pointer. The transition AIMED→HOME happens on any control write or control read. A soft reset forces either state to HOME.

Around the pointers, the block keeps both register files and applies the power-up and command-driven reset values. It decodes the line format (parity, stop bits, character length and the overall clock divisor) for the serial shifters that sit downstream. It also forwards transmit bytes, latches received bytes, and pulses a per-channel strobe whenever a line-format register is written.

Top module: `dscc_regbank`

## Requirements
- R1: `host_addr[0]` selects control (0) or data (1); `host_addr[1]` selects channel A (0) or B (1); an access to one channel leaves the other channel's registers and outputs unchanged.
- R2: A control write while the pointer is 0 loads the pointer from `host_wdata[2:0]`; when `host_wdata[5:3]` equals 3'b001, 8 is added so that registers 8 to 15 are reached.
- R3: A control read returns the read register at the current pointer; after any control read, and after a control write to a nonzero register, the pointer is 0 again.
- R4: Writes to write registers 12 and 13 are also stored in read registers 12 and 13.
- R5: Writing register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A and 11 resets both; such a write is not stored; with bits 7:6 = 00 the value is stored.
- R6: Reset values (at `rst_n` and on a soft reset): write register 4 = 0x04, 9 = 0xC0, 11 = 0x08, 14 = 0x30, 15 = 0xF8, all others 0; read register 1 = 0x07; read register 0 = 0x44, or 0x7C for a channel flagged in `DISABLED_MASK`; the pointer returns to 0.
- R7: Write register 4 bit 0 enables parity and bit 1 selects even parity; bits 3:2 = 11 select two stop bits and any other value selects one.
- R8: Write register 5 bits 6:5 select the character length: 00 = 5, 01 = 7, 10 = 6, 11 = 8 bits.
- R9: `clk_div` = 2 × ({WR13, WR12} + 2) × S, where S is 1, 16, 32 or 64 for write register 4 bits 7:6 = 00, 01, 10, 11.
- R10: A data-port write sets read register 0 bit 2 and read register 1 bit 0. In the cycle after the write, `tx_push` pulses with the byte on `tx_data`, but only when write register 5 bit 3 is set.
- R11: An `rx_strobe` is accepted only when write register 3 bit 0 is set and read register 0 bit 0 is clear, or is being cleared by a data read in the same cycle. Acceptance sets that bit and latches the byte. A data read returns the latched byte and clears the bit. A strobe that is not accepted is dropped.
- R12: `params_changed` of a channel pulses for one cycle, the cycle after a write to its register 4, 5, 12 or 13, and at no other time.
- R13: Command values in `host_wdata[5:3]` other than 3'b001 do not change the pointer loaded from bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Bit 0 control/data, bit 1 channel |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for the addressed port |
| rx_strobe | input | 2 | Per-channel received-byte strobe |
| rx_byte | input | 2x8 | Per-channel received byte |
| tx_push | output | 2 | Per-channel transmit pulse |
| tx_data | output | 2x8 | Per-channel transmit byte |
| wreg_out | output | 2x16x8 | Write register contents of both channels |
| par_en | output | 2 | Parity enabled |
| par_even | output | 2 | Even parity selected |
| two_stop | output | 2 | Two stop bits |
| data_bits | output | 2x4 | Character length, 5 to 8 |
| clk_div | output | 2x24 | Input clocks per bit |
| params_changed | output | 2 | Line-format register written |

## Verification
The collision of interest is a host data-port read and an `rx_strobe` that land on the same channel in the same cycle while a byte is already waiting. The bench fills the receive slot, then drives the read and the next strobe on the same clock edge. The read must return the old byte. The new byte must be accepted rather than dropped: read register 0 bit 0 must still be set afterwards, and a second data read must return the new byte.

// File: rtl/dscc_pkg.sv
package dscc_pkg;
    localparam int CHANS     = 2;
    localparam int REG_COUNT = 16;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int BRG_W     = 2 * BYTE_W;
    localparam int DIV_W     = BRG_W + 8;
    localparam int BITS_W    = 4;

    localparam logic [IDX_W-1:0] IDX_RXCFG  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_FORMAT = 4'd4;
    localparam logic [IDX_W-1:0] IDX_TXCFG  = 4'd5;
    localparam logic [IDX_W-1:0] IDX_MASTER = 4'd9;
    localparam logic [IDX_W-1:0] IDX_BRG_LO = 4'd12;
    localparam logic [IDX_W-1:0] IDX_BRG_HI = 4'd13;

    localparam logic [2:0] CMD_POINT_HIGH = 3'b001;

    typedef enum logic {
        PTR_HOME,
        PTR_AIMED
    } ptr_state_t;

    function automatic logic [BYTE_W-1:0] wr_default(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd4:    return 8'h04;
            4'd9:    return 8'hC0;
            4'd11:   return 8'h08;
            4'd14:   return 8'h30;
            4'd15:   return 8'hF8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] rr_default(input logic [IDX_W-1:0] idx,
                                                     input logic disabled);
        case (idx)
            4'd0:    return disabled ? 8'h7C : 8'h44;
            4'd1:    return 8'h07;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/dscc_ptr_fsm.sv
module dscc_ptr_fsm
    import dscc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctrl_wr,
    input  logic             ctrl_rd,
    input  logic [5:0]       cmd_byte,
    output logic [IDX_W-1:0] ptr
);
    ptr_state_t       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W-1:0] load_val;

    always_comb begin
        load_val = {(cmd_byte[5:3] == CMD_POINT_HIGH), cmd_byte[2:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_HOME;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            PTR_HOME: begin
                if (ctrl_wr && (load_val != '0)) begin
                    state_d = PTR_AIMED;
                    ptr_d   = load_val;
                end
            end
            PTR_AIMED: begin
                if (ctrl_wr || ctrl_rd) begin
                    state_d = PTR_HOME;
                    ptr_d   = '0;
                end
            end
        endcase
        if (soft_rst) begin
            state_d = PTR_HOME;
            ptr_d   = '0;
        end
    end

    always_comb begin
        ptr = (state_q == PTR_AIMED) ? ptr_q : '0;
    end

    assert_read_homes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> (ptr == '0));

    assert_write_homes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != '0 && ctrl_wr) |=> (ptr == '0));

    assert_point_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0 && ctrl_wr && !soft_rst && cmd_byte[5:3] == CMD_POINT_HIGH) |=> ptr[IDX_W-1]);

    assert_low_select_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0 && ctrl_wr && !soft_rst && cmd_byte[2:0] != 3'd0) |=> (ptr[2:0] == $past(cmd_byte[2:0])));
endmodule

// File: rtl/dscc_chan_regs.sv
module dscc_chan_regs
    import dscc_pkg::*;
#(
    parameter bit DISABLED = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              soft_rst,
    input  logic                              reg_wr,
    input  logic [IDX_W-1:0]                  reg_idx,
    input  logic [BYTE_W-1:0]                 reg_wdata,
    input  logic [IDX_W-1:0]                  rd_idx,
    input  logic                              data_wr,
    input  logic                              data_rd,
    input  logic                              rx_strobe,
    input  logic [BYTE_W-1:0]                 rx_byte,
    output logic [REG_COUNT-1:0][BYTE_W-1:0]  wregs,
    output logic [BYTE_W-1:0]                 rr_sel,
    output logic [BYTE_W-1:0]                 rx_hold,
    output logic                              params_changed,
    output logic                              tx_push,
    output logic [BYTE_W-1:0]                 tx_data
);
    logic [REG_COUNT-1:0][BYTE_W-1:0] wr_q;
    logic [REG_COUNT-1:0][BYTE_W-1:0] rr_q;
    logic                             rx_accept;
    logic                             fmt_hit;

    always_comb begin
        fmt_hit = reg_wr && ((reg_idx == IDX_FORMAT) || (reg_idx == IDX_TXCFG) ||
                             (reg_idx == IDX_BRG_LO) || (reg_idx == IDX_BRG_HI));
        rx_accept = rx_strobe && wr_q[IDX_RXCFG][0] && (!rr_q[0][0] || data_rd);
        wregs  = wr_q;
        rr_sel = rr_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                wr_q[i] <= wr_default(IDX_W'(i));
                rr_q[i] <= rr_default(IDX_W'(i), DISABLED);
            end
            rx_hold        <= '0;
            params_changed <= 1'b0;
            tx_push        <= 1'b0;
            tx_data        <= '0;
        end else if (soft_rst) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                wr_q[i] <= wr_default(IDX_W'(i));
                rr_q[i] <= rr_default(IDX_W'(i), DISABLED);
            end
            rx_hold        <= '0;
            params_changed <= 1'b0;
            tx_push        <= 1'b0;
        end else begin
            params_changed <= fmt_hit;
            tx_push        <= data_wr && wr_q[IDX_TXCFG][3];
            if (reg_wr) begin
                wr_q[reg_idx] <= reg_wdata;
                if ((reg_idx == IDX_BRG_LO) || (reg_idx == IDX_BRG_HI)) begin
                    rr_q[reg_idx] <= reg_wdata;
                end
            end
            if (data_wr) begin
                tx_data    <= reg_wdata;
                rr_q[0][2] <= 1'b1;
                rr_q[1][0] <= 1'b1;
            end
            if (data_rd) begin
                rr_q[0][0] <= 1'b0;
            end
            if (rx_accept) begin
                rr_q[0][0] <= 1'b1;
                rx_hold    <= rx_byte;
            end
        end
    end

    assert_mirror_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_BRG_LO && !soft_rst) |=> (rr_q[IDX_BRG_LO] == $past(reg_wdata)));

    assert_mirror_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_BRG_HI && !soft_rst) |=> (rr_q[IDX_BRG_HI] == $past(reg_wdata)));

    assert_soft_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (wr_q[IDX_MASTER] == 8'hC0 && rr_q[1] == 8'h07 && !rr_q[0][0]));

    assert_param_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        params_changed |-> $past(reg_wr && !soft_rst));

    assert_rx_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_strobe && !soft_rst) |=> !rr_q[0][0]);

    assert_tx_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(data_wr && wr_q[IDX_TXCFG][3]));
endmodule

// File: rtl/dscc_line_decode.sv
module dscc_line_decode
    import dscc_pkg::*;
(
    input  logic [1:0]        par_field,
    input  logic [1:0]        stop_field,
    input  logic [1:0]        scale_field,
    input  logic [1:0]        len_field,
    input  logic [BYTE_W-1:0] brg_lo,
    input  logic [BYTE_W-1:0] brg_hi,
    output logic              par_en,
    output logic              par_even,
    output logic              two_stop,
    output logic [BITS_W-1:0] data_bits,
    output logic [DIV_W-1:0]  clk_div
);
    logic [BRG_W:0]  brg_plus2;
    logic [2:0]      scale_sh;
    logic [DIV_W-1:0] base_div;

    always_comb begin
        par_en   = par_field[0];
        par_even = par_field[1];
        two_stop = (stop_field == 2'b11);
        case (len_field)
            2'b00:   data_bits = 4'd5;
            2'b01:   data_bits = 4'd7;
            2'b10:   data_bits = 4'd6;
            default: data_bits = 4'd8;
        endcase
        case (scale_field)
            2'b00:   scale_sh = 3'd0;
            2'b01:   scale_sh = 3'd4;
            2'b10:   scale_sh = 3'd5;
            default: scale_sh = 3'd6;
        endcase
        brg_plus2 = {1'b0, brg_hi, brg_lo} + (BRG_W+1)'(2);
        base_div  = DIV_W'(brg_plus2) << 1;
        clk_div   = base_div << scale_sh;
    end
endmodule

// File: rtl/dscc_regbank.sv
module dscc_regbank
    import dscc_pkg::*;
#(
    parameter logic [1:0] DISABLED_MASK = 2'b00
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          host_sel,
    input  logic                                          host_write,
    input  logic [1:0]                                    host_addr,
    input  logic [7:0]                                    host_wdata,
    output logic [7:0]                                    host_rdata,
    input  logic [1:0]                                    rx_strobe,
    input  logic [1:0][7:0]                               rx_byte,
    output logic [1:0]                                    tx_push,
    output logic [1:0][7:0]                               tx_data,
    output logic [1:0][15:0][7:0]                         wreg_out,
    output logic [1:0]                                    par_en,
    output logic [1:0]                                    par_even,
    output logic [1:0]                                    two_stop,
    output logic [1:0][3:0]                               data_bits,
    output logic [1:0][23:0]                              clk_div,
    output logic [1:0]                                    params_changed
);
    logic [CHANS-1:0][IDX_W-1:0]  ptr_w;
    logic [CHANS-1:0]             wr9_w;
    logic [CHANS-1:0]             soft_rst_w;
    logic [CHANS-1:0][BYTE_W-1:0] rr_sel_w;
    logic [CHANS-1:0][BYTE_W-1:0] rx_hold_w;
    logic                         any_wr9;

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        logic hit, ctrl_wr, ctrl_rd, data_wr, data_rd, reg_wr;

        always_comb begin
            hit      = host_sel && (host_addr[1] == 1'(c));
            ctrl_wr  = hit && host_write && !host_addr[0];
            ctrl_rd  = hit && !host_write && !host_addr[0];
            data_wr  = hit && host_write && host_addr[0];
            data_rd  = hit && !host_write && host_addr[0];
            wr9_w[c] = ctrl_wr && (ptr_w[c] == IDX_MASTER);
            reg_wr   = ctrl_wr && (ptr_w[c] != '0) &&
                       !(wr9_w[c] && (host_wdata[7:6] != 2'b00));
        end

        dscc_ptr_fsm u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst_w[c]),
            .ctrl_wr  (ctrl_wr),
            .ctrl_rd  (ctrl_rd),
            .cmd_byte (host_wdata[5:0]),
            .ptr      (ptr_w[c])
        );

        dscc_chan_regs #(
            .DISABLED (DISABLED_MASK[c])
        ) u_regs (
            .clk            (clk),
            .rst_n          (rst_n),
            .soft_rst       (soft_rst_w[c]),
            .reg_wr         (reg_wr),
            .reg_idx        (ptr_w[c]),
            .reg_wdata      (host_wdata),
            .rd_idx         (ptr_w[c]),
            .data_wr        (data_wr),
            .data_rd        (data_rd),
            .rx_strobe      (rx_strobe[c]),
            .rx_byte        (rx_byte[c]),
            .wregs          (wreg_out[c]),
            .rr_sel         (rr_sel_w[c]),
            .rx_hold        (rx_hold_w[c]),
            .params_changed (params_changed[c]),
            .tx_push        (tx_push[c]),
            .tx_data        (tx_data[c])
        );

        dscc_line_decode u_line (
            .par_field   (wreg_out[c][IDX_FORMAT][1:0]),
            .stop_field  (wreg_out[c][IDX_FORMAT][3:2]),
            .scale_field (wreg_out[c][IDX_FORMAT][7:6]),
            .len_field   (wreg_out[c][IDX_TXCFG][6:5]),
            .brg_lo      (wreg_out[c][IDX_BRG_LO]),
            .brg_hi      (wreg_out[c][IDX_BRG_HI]),
            .par_en      (par_en[c]),
            .par_even    (par_even[c]),
            .two_stop    (two_stop[c]),
            .data_bits   (data_bits[c]),
            .clk_div     (clk_div[c])
        );

        assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (data_bits[c] >= 4'd5) && (data_bits[c] <= 4'd8));

        assert_div_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
            clk_div[c] >= 24'd4);
    end

    always_comb begin
        any_wr9       = |wr9_w;
        soft_rst_w[0] = any_wr9 && host_wdata[7];
        soft_rst_w[1] = any_wr9 && host_wdata[6];
        host_rdata    = host_addr[0] ? rx_hold_w[host_addr[1]] : rr_sel_w[host_addr[1]];
    end

    assert_reset_unstored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr9_w[0] && host_wdata[7:6] == 2'b01) |=> (wreg_out[0][IDX_MASTER] == $past(wreg_out[0][IDX_MASTER])));

    assert_isolation_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_write && host_addr[1] && !any_wr9) |=> $stable(wreg_out[0]));
endmodule

// File: tb/dscc_regbank_test.sv
`timescale 1ns/1ps
module dscc_regbank_test;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_sel = 1'b0;
    logic             host_write = 1'b0;
    logic [1:0]       host_addr = 2'b00;
    logic [7:0]       host_wdata = 8'h00;
    logic [7:0]       host_rdata;
    logic [1:0]       rx_strobe = 2'b00;
    logic [1:0][7:0]  rx_byte = '0;
    logic [1:0]       tx_push;
    logic [1:0][7:0]  tx_data;
    logic [1:0][15:0][7:0] wreg_out;
    logic [1:0]       par_en, par_even, two_stop, params_changed;
    logic [1:0][3:0]  data_bits;
    logic [1:0][23:0] clk_div;

    int checks = 0;
    int errors = 0;
    logic [1:0] last_pc;
    logic [1:0] last_tx;
    logic [7:0] rd;

    localparam logic [1:0] CTRL_A = 2'b00, DATA_A = 2'b01, CTRL_B = 2'b10;

    dscc_regbank uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_push(tx_push), .tx_data(tx_data),
        .wreg_out(wreg_out), .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
        .data_bits(data_bits), .clk_div(clk_div), .params_changed(params_changed)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_write = 1'b0;
        last_pc = params_changed;
        last_tx = tx_push;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_write = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic set_reg(input int ch, input int idx, input logic [7:0] v);
        logic [1:0] ca;
        ca = {1'(ch), 1'b0};
        host_wr(ca, (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx));
        host_wr(ca, v);
    endtask

    task automatic get_rr(input int ch, input int idx, output logic [7:0] d);
        logic [1:0] ca;
        ca = {1'(ch), 1'b0};
        if (idx != 0) host_wr(ca, (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx));
        host_rd(ca, d);
    endtask

    task automatic rx_pulse(input int ch, input logic [7:0] b);
        @(negedge clk);
        rx_strobe[ch] = 1'b1; rx_byte[ch] = b;
        @(negedge clk);
        rx_strobe = 2'b00;
    endtask

    task automatic t_reset;
        get_rr(0, 0, rd); chk("R6 rr0 A", rd, 8'h44);
        get_rr(1, 1, rd); chk("R6 rr1 B", rd, 8'h07);
        chk("R6 wr4", wreg_out[0][4], 8'h04);
        chk("R6 wr9", wreg_out[0][9], 8'hC0);
        chk("R6 wr11", wreg_out[1][11], 8'h08);
        chk("R6 wr14", wreg_out[0][14], 8'h30);
        chk("R6 wr15", wreg_out[1][15], 8'hF8);
        chk("R8 reset length", data_bits[0], 5);
        chk("R9 reset divisor", clk_div[0], 4);
        chk("R7 reset parity", {par_en[0], two_stop[0]}, 0);
    endtask

    task automatic t_pointer;
        host_rd(CTRL_A, rd); chk("R3 read at ptr0", rd, 8'h44);
        get_rr(0, 1, rd); chk("R3 read at ptr1", rd, 8'h07);
        host_rd(CTRL_A, rd); chk("R3 ptr homes after read", rd, 8'h44);
        set_reg(0, 12, 8'h5A);
        chk("R2 point high write", wreg_out[0][12], 8'h5A);
        host_rd(CTRL_A, rd); chk("R3 ptr homes after write", rd, 8'h44);
        get_rr(0, 12, rd); chk("R4 mirror 12", rd, 8'h5A);
    endtask

    task automatic t_cmd_other;
        host_wr(CTRL_A, 8'h2C);
        host_wr(CTRL_A, 8'h81);
        chk("R13 other cmd reaches wr4", wreg_out[0][4], 8'h81);
        chk("R13 wr12 untouched", wreg_out[0][12], 8'h5A);
    endtask

    task automatic t_params;
        set_reg(0, 4, 8'h4F); chk("R12 pulse wr4", last_pc, 2'b01);
        chk("R7 parity even two stop", {par_en[0], par_even[0], two_stop[0]}, 3'b111);
        set_reg(0, 5, 8'h60); chk("R12 pulse wr5", last_pc, 2'b01);
        chk("R8 length 8", data_bits[0], 8);
        set_reg(0, 12, 8'h0A); chk("R12 pulse wr12", last_pc, 2'b01);
        set_reg(0, 13, 8'h01); chk("R12 pulse wr13", last_pc, 2'b01);
        get_rr(0, 13, rd); chk("R4 mirror 13", rd, 8'h01);
        chk("R9 div x16", clk_div[0], 8576);
        set_reg(0, 11, 8'h55); chk("R12 no pulse wr11", last_pc, 2'b00);
        set_reg(0, 4, 8'h85);
        chk("R7 odd one stop", {par_en[0], par_even[0], two_stop[0]}, 3'b100);
        chk("R9 div x32", clk_div[0], 17152);
        set_reg(0, 4, 8'hC8);
        chk("R7 stop 10 is one", {par_en[0], two_stop[0]}, 2'b00);
        chk("R9 div x64", clk_div[0], 34304);
        set_reg(0, 5, 8'h20); chk("R8 length 7", data_bits[0], 7);
        set_reg(0, 5, 8'h40); chk("R8 length 6", data_bits[0], 6);
    endtask

    task automatic t_channels;
        set_reg(1, 5, 8'h60);
        chk("R1 channel B length", data_bits[1], 8);
        chk("R1 channel A kept", data_bits[0], 6);
        chk("R1 pulse only B", last_pc, 2'b10);
    endtask

    task automatic t_tx;
        host_wr(DATA_A, 8'h3C); chk("R10 no push when disabled", last_tx, 2'b00);
        get_rr(0, 0, rd); chk("R10 tx empty bit", rd[2], 1);
        get_rr(0, 1, rd); chk("R10 all sent bit", rd[0], 1);
        set_reg(0, 5, 8'h68);
        host_wr(DATA_A, 8'hC3);
        chk("R10 push A only", last_tx, 2'b01);
        chk("R10 tx byte", tx_data[0], 8'hC3);
    endtask

    task automatic t_rx;
        rx_pulse(0, 8'h99);
        get_rr(0, 0, rd); chk("R11 dropped when rx off", rd, 8'h44);
        set_reg(0, 3, 8'h01);
        rx_pulse(0, 8'hA5);
        get_rr(0, 0, rd); chk("R11 rx available", rd, 8'h45);
        rx_pulse(0, 8'h11);
        host_rd(DATA_A, rd); chk("R11 overrun dropped", rd, 8'hA5);
        get_rr(0, 0, rd); chk("R11 read clears", rd, 8'h44);
    endtask

    task automatic t_collision;
        rx_pulse(0, 8'h22);
        @(negedge clk);
        host_sel = 1'b1; host_write = 1'b0; host_addr = DATA_A;
        rx_strobe[0] = 1'b1; rx_byte[0] = 8'h33;
        #1 rd = host_rdata;
        @(negedge clk);
        host_sel = 1'b0; rx_strobe = 2'b00;
        chk("R11 collision old byte", rd, 8'h22);
        get_rr(0, 0, rd); chk("R11 collision kept avail", rd, 8'h45);
        host_rd(DATA_A, rd); chk("R11 collision new byte", rd, 8'h33);
    endtask

    task automatic t_softreset;
        set_reg(1, 4, 8'h4F);
        set_reg(0, 9, 8'h10); chk("R5 code 00 stored", wreg_out[0][9], 8'h10);
        set_reg(0, 9, 8'h40);
        chk("R5 B reset", wreg_out[1][4], 8'h04);
        chk("R5 A wr9 not stored", wreg_out[0][9], 8'h10);
        chk("R5 A kept", wreg_out[0][12], 8'h0A);
        host_rd(CTRL_A, rd); chk("R3 ptr home after cmd", rd, 8'h44);
        set_reg(1, 13, 8'h22);
        set_reg(1, 9, 8'h80);
        chk("R5 A reset wr12", wreg_out[0][12], 8'h00);
        chk("R6 A wr9 default", wreg_out[0][9], 8'hC0);
        chk("R5 B kept", wreg_out[1][13], 8'h22);
        set_reg(0, 13, 8'h07);
        set_reg(1, 9, 8'hC0);
        chk("R5 both B", wreg_out[1][13], 8'h00);
        chk("R5 both A", wreg_out[0][13], 8'h00);
        get_rr(0, 13, rd); chk("R6 mirror cleared", rd, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_pointer;
        t_cmd_other;
        t_params;
        t_channels;
        t_tx;
        t_rx;
        t_collision;
        t_softreset;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule